// File: doc/BRIEF.md
# Two-Phase Full-Frame CCD Clock Sequencer

This block produces the logic-level phase enables for a two-phase full-frame CCD. A start strobe in idle begins a frame. The sequencer holds both vertical phases low for a programmable integration length. It then reads the frame out line by line. For each line it pulses the first vertical phase, waits a short gap, and pulses the second vertical phase. The row enters the horizontal register when that second phase falls. After a settle interval it clocks the horizontal phases for a fixed number of pixel counts. Level translation, drivers, biasing and video sampling are handled elsewhere.

All durations are parameters counted in system-clock cycles. The line count, the pixels per line, the pixel period, the vertical pulse width, the gap between the vertical pulses, the horizontal settle time and the reset-gate width are all set this way. The reset gate pulses from a free-running pixel timer, so it never stops, whatever the frame state. Horizontal shifting always begins on a pixel boundary of that timer. This keeps every reset pulse inside the high half of the first horizontal phase.

Top module: `ccd_clock_sequencer`

## Requirements
- R1: Reset state:
  - `v1_o`, `v2_o` and `h2_o` are 0 and `h1_o` is 1.
  - `frame_active_o`, `line_active_o` and `frame_done_o` are 0.
  - The pixel timer starts at phase 0.
- R2: Start and integration:
  - A start seen at a clock edge while idle raises `frame_active_o` from the next cycle.
  - Both vertical phases then stay low for max(L,1) cycles, where L is `int_len_i` captured with the start.
  - `v1_o` rises after that.
- R3: Vertical transfer:
  - `v1_o` is high for exactly VW cycles.
  - Both vertical phases are then low for exactly VGAP cycles.
  - `v2_o` is then high for exactly VW cycles.
  - `v1_o` and `v2_o` are never high together.
- R4: `h1_o` is high and `h2_o` low in every cycle where a vertical phase is high, including the cycle in which `v2_o` falls.
- R5: Settle before shifting:
  - After `v2_o` falls, the sequencer waits at least HS cycles.
  - It then waits further until the pixel timer wraps, so shifting starts at pixel phase 0.
  - The first rise of `h2_o` therefore comes between HS+PIX_CYC/2 and HS+PIX_CYC-1+PIX_CYC/2 cycles after the fall, counting the fall cycle as 1.
- R6: Horizontal shifting:
  - `h2_o` is the complement of `h1_o` in every cycle.
  - While shifting, `h1_o` is high for the first PIX_CYC/2 cycles of each pixel period.
  - Exactly PIXELS rising edges of `h2_o` occur per line.
- R7: Reset gate:
  - `rg_o` is high for RG_W cycles at the start of every PIX_CYC-cycle pixel period, in every state, idle and integration included.
  - It is high only while `h1_o` is high.
- R8: Frame structure:
  - A frame has exactly LINES falling edges of `v2_o`.
  - `line_active_o` is high from the first `v1_o` cycle to the last shifting cycle, and never while `frame_active_o` is low.
- R9: End of frame:
  - After the last pixel of the last line, the sequencer returns to idle.
  - `frame_done_o` is high for exactly one cycle, the first cycle in which `frame_active_o` is low.
- R10: Start while busy:
  - A start strobe while `frame_active_o` is high is ignored.
  - The frame keeps its LINES lines, and no new frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-exposure strobe, honoured only in idle |
| int_len_i | input | INT_W | Integration length in cycles, captured with start |
| v1_o | output | 1 | Vertical phase 1 enable |
| v2_o | output | 1 | Vertical phase 2 enable |
| h1_o | output | 1 | Horizontal phase 1 enable |
| h2_o | output | 1 | Horizontal phase 2 enable |
| rg_o | output | 1 | Reset-gate pulse enable |
| frame_active_o | output | 1 | High from accepted start until readout ends |
| line_active_o | output | 1 | High during vertical transfer, settle and shifting |
| frame_done_o | output | 1 | One-cycle pulse when the frame completes |

## Verification
The bench runs frames with zero, one and longer integration lengths. A design that used zero literally would skip integration or hang, and the integration count exposes this. It measures settle-to-first-shift latency to catch shifting that starts off a pixel boundary, which would clip the first H1 half-period or misplace the reset pulse. It counts H2 rises per line and V2 falls per frame, catching off-by-one terminal counts. It also strobes start in mid-readout and resets mid-frame, where a careless design would restart the frame or leave a phase high.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_INTEG,
      ST_V1,
      ST_VGAP,
      ST_V2,
      ST_SETTLE,
      ST_SHIFT
   } seq_state_t;
endpackage

// File: rtl/ccd_pixel_timer.sv
// Free-running pixel-period timer: drives the reset gate continuously and
// shapes the horizontal phase while shifting is enabled.
module ccd_pixel_timer #(
   parameter int unsigned PIX_CYC = 20,
   parameter int unsigned RG_W    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shift_en,
   output logic pix_last,
   output logic rg,
   output logic h1
);
   localparam int unsigned PH_W = (PIX_CYC > 2) ? $clog2(PIX_CYC) : 1;
   localparam int unsigned HALF = PIX_CYC / 2;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(PIX_CYC - 1);
   localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);
   localparam logic [PH_W-1:0] PH_RG   = PH_W'(RG_W);
   localparam bit POW2 = ((1 << PH_W) == PIX_CYC);

   logic [PH_W-1:0] ph;

   generate
      if (POW2) begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ph <= '0;
            else        ph <= ph + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             ph <= '0;
            else if (ph == PH_LAST) ph <= '0;
            else                    ph <= ph + 1'b1;
         end
      end
   endgenerate

   assign pix_last = (ph == PH_LAST);
   assign rg       = (ph < PH_RG);
   assign h1       = shift_en ? (ph < PH_HALF) : 1'b1;
endmodule

// File: rtl/ccd_line_fsm.sv
// Frame and line sequencing: integration, vertical transfer, settle, shift.
module ccd_line_fsm
   import ccd_seq_pkg::*;
#(
   parameter int unsigned LINES  = 4128,
   parameter int unsigned PIXELS = 4145,
   parameter int unsigned VW     = 1600,
   parameter int unsigned VGAP   = 8,
   parameter int unsigned HS     = 80,
   parameter int unsigned INT_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [INT_W-1:0] int_len,
   input  logic             pix_last,
   output logic             v1,
   output logic             v2,
   output logic             shift_en,
   output logic             frame_active,
   output logic             line_active,
   output logic             frame_done
);
   localparam int unsigned VMAX   = (VW > VGAP) ? VW : VGAP;
   localparam int unsigned DMAX   = (VMAX > HS) ? VMAX : HS;
   localparam int unsigned DW0    = (DMAX > 1) ? $clog2(DMAX) : 1;
   localparam int unsigned DUR_W  = (INT_W > DW0) ? INT_W : DW0;
   localparam int unsigned LN_W   = (LINES > 1) ? $clog2(LINES) : 1;
   localparam int unsigned PX_W   = (PIXELS > 1) ? $clog2(PIXELS) : 1;
   localparam logic [DUR_W-1:0] D_VW   = DUR_W'(VW - 1);
   localparam logic [DUR_W-1:0] D_GAP  = DUR_W'(VGAP - 1);
   localparam logic [DUR_W-1:0] D_HS   = DUR_W'(HS - 1);
   localparam logic [LN_W-1:0]  LN_END = LN_W'(LINES - 1);
   localparam logic [PX_W-1:0]  PX_END = PX_W'(PIXELS - 1);

   seq_state_t       state;
   logic [DUR_W-1:0] cnt;
   logic [LN_W-1:0]  line_cnt;
   logic [PX_W-1:0]  pix_cnt;
   logic             cnt_zero;
   logic             line_end;

   assign cnt_zero = (cnt == '0);
   assign line_end = pix_last && (pix_cnt == PX_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         line_cnt   <= '0;
         pix_cnt    <= '0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state    <= ST_INTEG;
                  line_cnt <= '0;
                  cnt      <= (int_len == '0) ? '0 : DUR_W'(int_len) - 1'b1;
               end
            end
            ST_INTEG: begin
               if (cnt_zero) begin
                  state <= ST_V1;
                  cnt   <= D_VW;
               end else cnt <= cnt - 1'b1;
            end
            ST_V1: begin
               if (cnt_zero) begin
                  state <= ST_VGAP;
                  cnt   <= D_GAP;
               end else cnt <= cnt - 1'b1;
            end
            ST_VGAP: begin
               if (cnt_zero) begin
                  state <= ST_V2;
                  cnt   <= D_VW;
               end else cnt <= cnt - 1'b1;
            end
            ST_V2: begin
               if (cnt_zero) begin
                  state <= ST_SETTLE;
                  cnt   <= D_HS;
               end else cnt <= cnt - 1'b1;
            end
            ST_SETTLE: begin
               if (!cnt_zero) cnt <= cnt - 1'b1;
               else if (pix_last) begin
                  state   <= ST_SHIFT;
                  pix_cnt <= '0;
               end
            end
            ST_SHIFT: begin
               if (line_end) begin
                  if (line_cnt == LN_END) begin
                     state      <= ST_IDLE;
                     frame_done <= 1'b1;
                  end else begin
                     state    <= ST_V1;
                     cnt      <= D_VW;
                     line_cnt <= line_cnt + 1'b1;
                  end
               end else if (pix_last) pix_cnt <= pix_cnt + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign v1           = (state == ST_V1);
   assign v2           = (state == ST_V2);
   assign shift_en     = (state == ST_SHIFT);
   assign frame_active = (state != ST_IDLE);
   assign line_active  = (state != ST_IDLE) && (state != ST_INTEG);
endmodule

// File: rtl/ccd_clock_sequencer.sv
module ccd_clock_sequencer #(
   parameter int unsigned LINES   = 4128,
   parameter int unsigned PIXELS  = 4145,
   parameter int unsigned PIX_CYC = 20,
   parameter int unsigned RG_W    = 2,
   parameter int unsigned VW      = 1600,
   parameter int unsigned VGAP    = 8,
   parameter int unsigned HS      = 80,
   parameter int unsigned INT_W   = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [INT_W-1:0] int_len_i,
   output logic             v1_o,
   output logic             v2_o,
   output logic             h1_o,
   output logic             h2_o,
   output logic             rg_o,
   output logic             frame_active_o,
   output logic             line_active_o,
   output logic             frame_done_o
);
   initial begin
      assert (PIX_CYC >= 2) else $error("PIX_CYC must be at least 2");
      assert (RG_W >= 1 && RG_W <= PIX_CYC / 2) else $error("RG_W out of range");
      assert (VW >= 1 && VGAP >= 1 && HS >= 1) else $error("durations must be nonzero");
      assert (LINES >= 1 && PIXELS >= 1) else $error("frame size must be nonzero");
      assert (INT_W >= 1 && INT_W <= 32) else $error("INT_W out of range");
   end

   logic shift_en;
   logic pix_last;
   logic h1;

   ccd_pixel_timer #(.PIX_CYC(PIX_CYC), .RG_W(RG_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .pix_last (pix_last),
      .rg       (rg_o),
      .h1       (h1)
   );

   ccd_line_fsm #(
      .LINES(LINES), .PIXELS(PIXELS), .VW(VW), .VGAP(VGAP), .HS(HS), .INT_W(INT_W)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start_i),
      .int_len      (int_len_i),
      .pix_last     (pix_last),
      .v1           (v1_o),
      .v2           (v2_o),
      .shift_en     (shift_en),
      .frame_active (frame_active_o),
      .line_active  (line_active_o),
      .frame_done   (frame_done_o)
   );

   assign h1_o = h1;
   assign h2_o = ~h1;
endmodule

// File: rtl/ccd_seq_checker.sv
module ccd_seq_checker #(
   parameter int unsigned VW = 1600
) (
   input logic clk,
   input logic rst_n,
   input logic v1,
   input logic v2,
   input logic h1,
   input logic rg,
   input logic frame_active,
   input logic line_active,
   input logic frame_done
);
   int unsigned v1_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  v1_run <= 0;
      else if (v1) v1_run <= v1_run + 1;
      else         v1_run <= 0;
   end

   a_r3_v_exclusive: assert property (@(posedge clk) disable iff (!rst_n) !(v1 && v2));
   a_r3_v1_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(v1) |-> (v1_run == VW));
   a_r4_h1_in_vxfer: assert property (@(posedge clk) disable iff (!rst_n)
      (v1 || v2) |-> h1);
   a_r7_rg_in_h1: assert property (@(posedge clk) disable iff (!rst_n) rg |-> h1);
   a_r2_quiet_integ: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_active && !line_active) |-> (!v1 && !v2));
   a_r8_line_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_active |-> !line_active);
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);
   a_r9_done_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (!frame_active && $past(frame_active)));
endmodule

bind ccd_clock_sequencer ccd_seq_checker #(.VW(VW)) u_seq_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .v1           (v1_o),
   .v2           (v2_o),
   .h1           (h1_o),
   .rg           (rg_o),
   .frame_active (frame_active_o),
   .line_active  (line_active_o),
   .frame_done   (frame_done_o)
);

// File: tb/test_ccd_clock_sequencer.sv
`timescale 1ns/1ps
module test_ccd_clock_sequencer;
   localparam int unsigned LINES = 3, PIXELS = 5, PIX_CYC = 4, RG_W = 1;
   localparam int unsigned VW = 3, VGAP = 2, HS = 2, INT_W = 8;
   localparam int unsigned HALF = PIX_CYC / 2;
   localparam int NTAB = 4;
   localparam int unsigned TAB_LEN [NTAB] = '{0, 1, 6, 13};
   localparam bit          TAB_POKE[NTAB] = '{1'b0, 1'b1, 1'b0, 1'b1};

   logic clk = 0, rst_n = 0, start = 0;
   logic [INT_W-1:0] int_len = '0;
   logic v1, v2, h1, h2, rg, fa, la, fd;
   int total = 0, bad = 0;

   always #2 clk = ~clk;

   ccd_clock_sequencer #(.LINES(LINES), .PIXELS(PIXELS), .PIX_CYC(PIX_CYC), .RG_W(RG_W),
      .VW(VW), .VGAP(VGAP), .HS(HS), .INT_W(INT_W)) i_ccd_clock_sequencer (
      .clk(clk), .rst_n(rst_n), .start_i(start), .int_len_i(int_len),
      .v1_o(v1), .v2_o(v2), .h1_o(h1), .h2_o(h2), .rg_o(rg),
      .frame_active_o(fa), .line_active_o(la), .frame_done_o(fd));

   // per-cycle monitor, sampled away from the active edge
   int e3 = 0, e4 = 0, e5 = 0, e6 = 0, e7 = 0, e9 = 0, done_cnt = 0;
   int v1_run, v2_run, gap_run, settle_run, h2_cnt, lines, integ, rg_run, rg_since;
   bit p_v1, p_v2, p_h2, p_rg, p_fa, in_gap, in_settle, line_seen, rg_seen;

   always @(negedge clk) begin
      if (!rst_n) begin
         v1_run = 0; v2_run = 0; gap_run = 0; settle_run = 0; h2_cnt = 0;
         lines = 0; integ = 0; rg_run = 0; rg_since = 0;
         p_v1 = 0; p_v2 = 0; p_h2 = 0; p_rg = 0; p_fa = 0;
         in_gap = 0; in_settle = 0; line_seen = 0; rg_seen = 0;
      end else begin
         if (fa && !p_fa) begin integ = 0; lines = 0; line_seen = 0; end
         if (h1 === h2) e6++;                       // R6 complement
         if (v1 && v2) e3++;                        // R3
         if ((v1 || v2) && !h1) e4++;               // R4
         if (rg && !h1) e7++;                       // R7
         if (fa && !la && !line_seen) integ++;      // R2
         if (v1 && !p_v1) begin                     // R6 per-line count
            if (line_seen && h2_cnt != PIXELS) e6++;
            line_seen = 1; h2_cnt = 0;
         end
         if (v1) v1_run++;
         else if (p_v1) begin
            if (v1_run != VW) e3++;
            v1_run = 0; in_gap = 1; gap_run = 0;
         end
         if (in_gap) begin
            if (v2) begin if (gap_run != VGAP) e3++; in_gap = 0; end
            else gap_run++;
         end
         if (v2) v2_run++;
         else if (p_v2) begin
            if (v2_run != VW) e3++;
            v2_run = 0; lines++; in_settle = 1; settle_run = 0;
         end
         if (in_settle) begin
            if (h2 && !p_h2) begin                  // R5 window
               if (settle_run < HS + HALF || settle_run > HS + PIX_CYC - 1 + HALF) e5++;
               in_settle = 0;
            end else settle_run++;
         end
         if (h2 && !p_h2) h2_cnt++;
         if (fd) begin
            if (!(p_fa && !fa)) e9++;
            if (line_seen && h2_cnt != PIXELS) e6++;
            line_seen = 0; done_cnt++;
         end
         if (rg) rg_run++;
         if (rg && !p_rg) begin
            if (rg_seen && rg_since != PIX_CYC) e7++;
            rg_seen = 1; rg_since = 0;
         end
         if (!rg && p_rg) begin
            if (rg_run != RG_W) e7++;
            rg_run = 0;
         end
         rg_since++;
         p_v1 = v1; p_v2 = v2; p_h2 = h2; p_rg = rg; p_fa = fa;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_frame(input int unsigned len, input bit poke);
      int s3 = e3, s4 = e4, s5 = e5, s6 = e6, s7 = e7, s9 = e9, sd = done_cnt;
      int waited = 0;
      int unsigned exp_int = (len == 0) ? 1 : len;
      @(negedge clk); int_len = INT_W'(len); start = 1;
      @(negedge clk); start = 0;
      if (poke) begin
         repeat (25) @(negedge clk);
         start = 1; @(negedge clk); start = 0;      // R10 stray start
      end
      while (done_cnt == sd && waited < 2000) begin @(negedge clk); waited++; end
      check(done_cnt == sd + 1, "R9 frame_done pulse count", done_cnt - sd, 1);
      check(integ == int'(exp_int), "R2 integration cycles", integ, int'(exp_int));
      check(lines == LINES, "R8 v2 falls per frame", lines, LINES);
      check(e3 == s3, "R3 vertical timing errors", e3 - s3, 0);
      check(e4 == s4, "R4 h1 low in vertical transfer", e4 - s4, 0);
      check(e5 == s5, "R5 settle window errors", e5 - s5, 0);
      check(e6 == s6, "R6 complement/pixel count errors", e6 - s6, 0);
      check(e7 == s7, "R7 reset gate errors", e7 - s7, 0);
      check(e9 == s9, "R9 done not at idle entry", e9 - s9, 0);
      repeat (12) @(negedge clk);
      check(fa == 0 && done_cnt == sd + 1, "R10 no extra frame", fa, 0);
   endtask

   initial begin
      #400000;
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset values
      check(v1 == 0 && v2 == 0, "R1 vertical low in reset", {v1, v2}, 0);
      check(h1 == 1 && h2 == 0, "R1 h1 high h2 low in reset", {h1, h2}, 2);
      check(fa == 0 && la == 0 && fd == 0, "R1 flags low in reset", {fa, la, fd}, 0);
      rst_n = 1;
      repeat (10) @(negedge clk);
      check(fa == 0 && v1 == 0, "R2 no frame without start", fa, 0);
      check(e7 == 0, "R7 reset gate pulses in idle", e7, 0);
      for (int i = 0; i < NTAB; i++) run_frame(TAB_LEN[i], TAB_POKE[i]);
      // mid-frame reset corner (R1)
      @(negedge clk); int_len = 2; start = 1;
      @(negedge clk); start = 0;
      repeat (20) @(negedge clk);
      rst_n = 0; #1;
      check(v1 == 0 && v2 == 0 && h1 == 1 && h2 == 0, "R1 phases after mid-frame reset",
            {v1, v2, h1, h2}, 2);
      check(fa == 0 && la == 0, "R1 flags after mid-frame reset", {fa, la}, 0);
      repeat (2) @(negedge clk);
      rst_n = 1;
      run_frame(3, 1'b0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule